// File: doc/BRIEF.md
# Banked Static Memory Array

This block assembles one wide, deep random-access memory out of a grid of identical small synchronous storage banks, each one byte wide. Banks placed side by side form byte lanes, so one word is spread across a row of banks that all see the same bank address and the same select. Stacking several such rows deepens the array. Row selection comes from a decoder that turns part of the word address into one-hot row selects.

A build-time parameter picks the address bits that choose the row. In contiguous mapping the most significant address bits pick the row, so each row holds one unbroken address region. In interleaved mapping the least significant address bits pick the row, so consecutive addresses alternate between rows. A bank built with 16 address bits holds 64K bytes. The default bank is smaller so that the default build stays light. Two lanes by two rows, as in the defaults, gives a 16-bit array twice the depth of one bank.

Access is synchronous. A read launched on one clock edge presents its word after that edge, so the latency is one cycle. The row index is registered alongside the read so that the output multiplexer follows the row that did the access. The address port is one bit wider than the configured depth, and any address beyond the depth is ignored.

Top module: `sram_array`

## Requirements
- R1: The array stores ROWS × 2^BANK_AW words of LANES × BANK_DW bits. A read (cs=1, we=0, address in range) on one rising edge places the word last written to that address on rdata until the next rising edge.
- R2: Each byte lane of a word is held independently. Words whose lanes carry different byte values read back with every lane intact.
- R3: With contiguous mapping, address bits [AW-1:BANK_AW] select the row and bits [BANK_AW-1:0] form the bank address. Row r therefore covers addresses r×2^BANK_AW to (r+1)×2^BANK_AW − 1.
- R4: With interleaved mapping, address bits [log2(ROWS)-1:0] select the row and the upper bits form the bank address. Even and odd addresses land in different rows and keep separate values.
- R5: While cs=0 no bank is selected, and a write presented with cs=0 leaves the stored contents unchanged.
- R6: rdata is all zeros in the cycle after any edge that did not take an in-range read, whether the array was deselected, writing or idle.
- R7: At most one row of banks is selected in any cycle.
- R8: A write changes only the addressed word. Neighbouring addresses keep their values.
- R9: An address with any bit set at or above position AW (the configured depth) selects no bank. A write to it changes nothing, and a read of it returns zeros.
- R10: While rst_n=0 at a rising edge, rdata is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Array select, active high |
| we | input | 1 | 1 = write, 0 = read, when cs=1 |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES×BANK_DW | Write word, lane 0 in the low byte |
| rdata | output | LANES×BANK_DW | Read word, one cycle after the read edge; zero otherwise |

## Verification
On every cycle the assertions check the select logic. No row is selected while the array is deselected or the address is out of range. At most one row is active, and the active row is the one the chosen mapping assigns to the address. They also check that the output is zero after any edge without a read. Data integrity can only be shown by the bench's scenarios, which run a contiguous and an interleaved instance side by side against one behavioural memory. These scenarios cover lane independence, row boundaries, even/odd separation, writes ignored while deselected or out of range, and the absence of any disturbance to neighbouring words.

// File: rtl/sram_arr_pkg.sv
// Package: shared types for the banked memory array.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package sram_arr_pkg;

    // Which address bits pick the row of banks.
    typedef enum logic {
        MAP_CONTIG     = 1'b0,
        MAP_INTERLEAVE = 1'b1
    } row_map_e;

endpackage

// File: rtl/sram_bank.sv
// Module: one synchronous byte-wide storage bank.
// Holds 2**AW entries of DW bits. It writes on sel&&wr_en and reads on
// sel&&!wr_en, with the read word registered (one cycle of latency).
// Assumes: the contents are not reset; only the read register is.
module sram_bank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Purpose: commit a selected write into the storage array.
    always_ff @(posedge clk) begin
        if (sel && wr_en) begin
            store[addr] <= wdata;
        end
    end

    // Purpose: capture the addressed entry on a selected read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (sel && !wr_en) begin
            rdata <= store[addr];
        end
    end

endmodule

// File: rtl/sram_row_decode.sv
// Module: splits the word address into a row index and a bank address,
// then produces one-hot row selects.
// Assumes: ROWS is a power of two and at least 2; ADDR_W >= BANK_AW+log2(ROWS).
module sram_row_decode
    import sram_arr_pkg::*;
#(
    parameter int       BANK_AW = 8,
    parameter int       ROWS    = 2,
    parameter int       ADDR_W  = 10,
    parameter row_map_e MAP     = MAP_CONTIG,
    localparam int      RB      = $clog2(ROWS),
    localparam int      AW      = BANK_AW + RB
) (
    input  logic               cs,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [RB-1:0]      row_idx,
    output logic [BANK_AW-1:0] bank_addr,
    output logic [ROWS-1:0]    row_cs
);
    // Purpose: flag addresses that fall inside the configured depth.
    always_comb begin
        hit = ((addr >> AW) == '0);
    end

    generate
        if (MAP == MAP_CONTIG) begin : g_contig
            // Purpose: high bits choose the row, low bits address the bank.
            always_comb begin
                row_idx   = addr[AW-1:BANK_AW];
                bank_addr = addr[BANK_AW-1:0];
            end
        end else begin : g_interleave
            // Purpose: low bits choose the row, high bits address the bank.
            always_comb begin
                row_idx   = addr[RB-1:0];
                bank_addr = addr[AW-1:RB];
            end
        end
    endgenerate

    // Purpose: one-hot row selects, all low when deselected or out of range.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            row_cs[r] = cs && hit && (row_idx == RB'(r));
        end
    end

endmodule

// File: rtl/sram_read_path.sv
// Module: registers the row index of a read and steers that row's word
// onto the output; returns zeros after any edge without a read.
// Assumes: row word outputs are valid one cycle after the read edge.
module sram_read_path #(
    parameter int  ROWS = 2,
    parameter int  WDW  = 16,
    localparam int RB   = $clog2(ROWS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_go,
    input  logic [RB-1:0]             row_idx,
    input  logic [ROWS-1:0][WDW-1:0]  row_data,
    output logic [WDW-1:0]            rdata
);
    logic [RB-1:0] row_q;
    logic          vld_q;

    // Purpose: remember which row answered the read and whether one occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= rd_go;
            if (rd_go) begin
                row_q <= row_idx;
            end
        end
    end

    // Purpose: select the answering row, or zeros with no read pending.
    always_comb begin
        rdata = vld_q ? row_data[row_q] : '0;
    end

endmodule

// File: rtl/sram_array.sv
// Module: top of the banked memory array. It builds a ROWS x LANES grid of
// byte banks, decodes rows from the address and registers the read steering.
// Assumes: ROWS and LANES are powers of two, and ROWS >= 2.
module sram_array
    import sram_arr_pkg::*;
#(
    parameter int       BANK_AW = 8,
    parameter int       BANK_DW = 8,
    parameter int       LANES   = 2,
    parameter int       ROWS    = 2,
    parameter int       ADDR_W  = BANK_AW + $clog2(ROWS) + 1,
    parameter row_map_e MAP     = MAP_CONTIG
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [LANES*BANK_DW-1:0]   wdata,
    output logic [LANES*BANK_DW-1:0]   rdata
);
    localparam int DW = LANES * BANK_DW;
    localparam int RB = $clog2(ROWS);

    logic                     hit;
    logic [RB-1:0]            row_idx;
    logic [BANK_AW-1:0]       bank_addr;
    logic [ROWS-1:0]          row_cs;
    logic [ROWS-1:0][DW-1:0]  row_data;
    logic                     rd_go;

    sram_row_decode #(
        .BANK_AW (BANK_AW),
        .ROWS    (ROWS),
        .ADDR_W  (ADDR_W),
        .MAP     (MAP)
    ) u_decode (
        .cs        (cs),
        .addr      (addr),
        .hit       (hit),
        .row_idx   (row_idx),
        .bank_addr (bank_addr),
        .row_cs    (row_cs)
    );

    // Purpose: a read is taken only when selected, reading and in range.
    always_comb begin
        rd_go = cs && !we && hit;
    end

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            for (genvar l = 0; l < LANES; l++) begin : g_lane
                sram_bank #(
                    .AW (BANK_AW),
                    .DW (BANK_DW)
                ) u_bank (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .sel   (row_cs[r]),
                    .wr_en (we),
                    .addr  (bank_addr),
                    .wdata (wdata[l*BANK_DW +: BANK_DW]),
                    .rdata (row_data[r][l*BANK_DW +: BANK_DW])
                );
            end
        end
    endgenerate

    sram_read_path #(
        .ROWS (ROWS),
        .WDW  (DW)
    ) u_rdpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .row_idx  (row_idx),
        .row_data (row_data),
        .rdata    (rdata)
    );

endmodule

// File: rtl/sram_array_chk.sv
// Module: property checker for the banked memory array, bound to its top.
// Assumes: the row selects come from the decoder inside the array.
module sram_array_chk
    import sram_arr_pkg::*;
#(
    parameter int       BANK_AW = 8,
    parameter int       ROWS    = 2,
    parameter int       ADDR_W  = 10,
    parameter int       DW      = 16,
    parameter row_map_e MAP     = MAP_CONTIG,
    localparam int      RB      = $clog2(ROWS),
    localparam int      AW      = BANK_AW + RB
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     rdata,
    input logic [ROWS-1:0]   row_cs
);
    logic          beyond;
    logic [RB-1:0] want_row;

    // Purpose: address above the configured depth.
    always_comb begin
        beyond = (addr[ADDR_W-1:0] >= ADDR_W'(ROWS << BANK_AW));
    end

    generate
        if (MAP == MAP_CONTIG) begin : g_c
            // Purpose: expected row under contiguous mapping.
            always_comb want_row = addr[AW-1:BANK_AW];
        end else begin : g_i
            // Purpose: expected row under interleaved mapping.
            always_comb want_row = addr[RB-1:0];
        end
    endgenerate

    // R5
    no_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> (row_cs == '0));

    // R7
    one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_cs));

    // R9
    beyond_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beyond |-> (row_cs == '0));

    // R3 R4
    row_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !beyond) |-> row_cs[want_row]);

    // R6
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !we) |=> (rdata == '0));

endmodule

bind sram_array sram_array_chk #(
    .BANK_AW (BANK_AW),
    .ROWS    (ROWS),
    .ADDR_W  (ADDR_W),
    .DW      (DW),
    .MAP     (MAP)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .we     (we),
    .addr   (addr),
    .rdata  (rdata),
    .row_cs (row_cs)
);

// File: tb/sram_array_tb.sv
// Bench: drives one contiguous and one interleaved array with identical
// stimulus and compares both against a behavioural memory every cycle.
module sram_array_tb;
    import sram_arr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BANK_AW    = 8;
    localparam int BANK_DW    = 8;
    localparam int LANES      = 2;
    localparam int ROWS       = 2;
    localparam int AW         = BANK_AW + $clog2(ROWS);
    localparam int ADDR_W     = AW + 1;
    localparam int DW         = LANES * BANK_DW;
    localparam int DEPTH      = 1 << AW;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata_c;
    logic [DW-1:0]     rdata_i;

    logic [DW-1:0] ref_mem [DEPTH];
    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_array #(
        .BANK_AW (BANK_AW), .BANK_DW (BANK_DW), .LANES (LANES),
        .ROWS (ROWS), .ADDR_W (ADDR_W), .MAP (MAP_CONTIG)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cs (cs), .we (we),
        .addr (addr), .wdata (wdata), .rdata (rdata_c)
    );

    sram_array #(
        .BANK_AW (BANK_AW), .BANK_DW (BANK_DW), .LANES (LANES),
        .ROWS (ROWS), .ADDR_W (ADDR_W), .MAP (MAP_INTERLEAVE)
    ) u_dut_il (
        .clk (clk), .rst_n (rst_n), .cs (cs), .we (we),
        .addr (addr), .wdata (wdata), .rdata (rdata_i)
    );

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string tag, input string inst);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) at %0t: actual %h expected %h", tag, inst, $time, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, check at the next falling edge.
    task automatic op(input logic c, input logic w, input logic [ADDR_W-1:0] a,
                      input logic [DW-1:0] d, input string tag);
        logic          in_rng;
        logic [DW-1:0] exp;
        cs = c; we = w; addr = a; wdata = d;
        in_rng = ((a >> AW) == 0);
        exp = (c && !w && in_rng) ? ref_mem[a[AW-1:0]] : '0;
        if (c && w && in_rng) ref_mem[a[AW-1:0]] = d;
        @(negedge clk);
        check(rdata_c, exp, tag, "contig");
        check(rdata_i, exp, tag, "interleave");
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 16'h3B1) ^ 16'hA55A);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: output cleared by reset
        check(rdata_c, '0, "R10", "contig");
        check(rdata_i, '0, "R10", "interleave");
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R6: fill every word; each write cycle leaves the output at zero
        for (int a = 0; a < DEPTH; a++) op(1, 1, ADDR_W'(a), pat(a), "R6");
        for (int a = 0; a < DEPTH; a++) op(1, 0, ADDR_W'(a), '0, "R1");

        // R2: distinct lane contents survive intact
        op(1, 1, ADDR_W'(7), 16'hFF00, "R2");
        op(1, 1, ADDR_W'(8), 16'h00FF, "R2");
        op(1, 0, ADDR_W'(7), '0, "R2");
        op(1, 0, ADDR_W'(8), '0, "R2");
        op(1, 1, ADDR_W'(9), 16'h12C4, "R2");
        op(1, 0, ADDR_W'(9), '0, "R2");

        // R3: words either side of the row boundary are distinct
        op(1, 1, ADDR_W'((1 << BANK_AW) - 1), 16'h0BAD, "R3");
        op(1, 1, ADDR_W'(1 << BANK_AW), 16'hF00D, "R3");
        op(1, 0, ADDR_W'((1 << BANK_AW) - 1), '0, "R3");
        op(1, 0, ADDR_W'(1 << BANK_AW), '0, "R3");
        op(1, 0, ADDR_W'(DEPTH - 1), '0, "R3");

        // R4: an even/odd pair keeps separate values
        op(1, 1, ADDR_W'(20), 16'hEEEE, "R4");
        op(1, 1, ADDR_W'(21), 16'h0D0D, "R4");
        op(1, 0, ADDR_W'(20), '0, "R4");
        op(1, 0, ADDR_W'(21), '0, "R4");

        // R5: writes and reads while deselected
        op(0, 1, ADDR_W'(30), 16'h7777, "R5");
        op(1, 0, ADDR_W'(30), '0, "R5");
        op(0, 0, ADDR_W'(30), '0, "R6");

        // R8: neighbours untouched by a write
        op(1, 1, ADDR_W'(100), 16'h5151, "R8");
        op(1, 0, ADDR_W'(99), '0, "R8");
        op(1, 0, ADDR_W'(101), '0, "R8");
        op(1, 0, ADDR_W'(100), '0, "R8");

        // R9: beyond the configured depth
        op(1, 1, ADDR_W'(DEPTH + 5), 16'h9999, "R9");
        op(1, 0, ADDR_W'(5), '0, "R9");
        op(1, 0, ADDR_W'(DEPTH + 5), '0, "R9");

        // R1 R7: random mix with a bias toward a small hot set
        for (int i = 0; i < 4000; i++) begin
            logic [ADDR_W-1:0] ra;
            ra = ($urandom_range(0, 3) == 0) ? ADDR_W'($urandom_range(0, 7))
                                              : ADDR_W'($urandom);
            op(($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1, ra,
               DW'($urandom), "R1");
        end

        finish_run();
    end

endmodule